// File: doc/BRIEF.md
# Byte-Wide Host Port with Shared Word Memory

This block lets an external processor that has only an 8-bit data bus reach a 16-bit on-chip memory of 1024 words. The host sees three registers: control, address and data. It moves every 16-bit quantity as two byte transfers. A dedicated byte-select input marks whether a transfer is the first byte or the second byte of the word. A bit in the control register decides whether the first byte is the low half or the high half of the word.

The host marks each transfer with an active-low data strobe. The register select, byte select, direction and write byte are all taken at the moment the strobe is seen going low. They are not decoded from the level of the direction line. The strobe is treated as a synchronous input to the block clock.

A core-side agent reaches the same memory through a plain word-wide port. That port reads with one cycle of latency. The core side also receives a host-to-core flag. The host sets the flag through the control register, and the core clears it with a pulse.

Top module: `byte_host_port`

## Requirements
- R1: `host_sel` picks the register: 2'b00 control, 2'b01 data with post-increment, 2'b10 address, 2'b11 data without increment. `host_half` = 0 marks the first byte of a word and 1 marks the second byte.
- R2: Only a falling edge of `host_strobe_n` starts a transfer. The fields are taken at the clock edge where the strobe is first seen low after being high. Changing them while the strobe stays low has no effect, and a strobe held low for many cycles performs only one transfer.
- R3: A first-byte data write only stages the byte, and memory is unchanged. The second-byte data write commits the assembled 16-bit word to the current address.
- R4: A first-byte data read fetches the whole word. The following second-byte read returns the other half of that fetched word, even if the core has rewritten the location in between.
- R5: Control bit 0 (byte order) = 0 makes the first byte the low half `[7:0]`. A value of 1 makes the first byte the high half `[15:8]`. The order applies to data and address transfers in both directions.
- R6: The address advances by one after the second byte of a data access with select 2'b01, and it wraps from 1023 to 0. A first-byte access does not advance it, and neither does select 2'b11.
- R7: The address register is written as two bytes and takes the assembled word's low 10 bits on the second byte. A read returns those bits zero-extended to 16 bits.
- R8: Writing control with bit 1 = 1 sets `host_flag`, and writing 0 there leaves it unchanged. A `core_flag_clr` pulse clears it. If the host sets and the core clears in the same cycle, the set wins. Control writes take effect on the first-byte cycle only. A control read returns `{6'b0, flag, order}` as the first byte and 0 as the second byte.
- R9: The core port writes when `core_en` and `core_we` are both high. When `core_en` is high and `core_we` is low, it returns `mem[core_addr]` on `core_rdata` one clock later. The core port and the host port share the same storage.
- R10: After reset, `host_rdata` = 0, `host_flag` = 0, control = 0 and address = 0.
- R11: `host_rdata` changes on the second clock edge after the strobe is sampled low. It holds its value through later write transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_strobe_n | input | 1 | Host data strobe, active low |
| host_sel | input | 2 | Register select |
| host_half | input | 1 | Byte select: 0 first byte, 1 second byte |
| host_rd | input | 1 | 1 = host read, 0 = host write |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte |
| host_flag | output | 1 | Host-to-core interrupt flag |
| core_en | input | 1 | Core port access enable |
| core_we | input | 1 | Core port write enable |
| core_addr | input | 10 | Core port word address |
| core_wdata | input | 16 | Core port write word |
| core_rdata | output | 16 | Core port read word |
| core_flag_clr | input | 1 | Core clears the host flag |

## Verification
The main patterns are two full sweeps over all 1024 words. In the first sweep the host fills memory with auto-increment in low-first order, and the core port reads every word back. In the second sweep the host reads every word back in high-first order. A mismatch in either sweep points to a fault in byte assembly, in byte order or in address stepping, and the wrap back to address 0 after the sweep is checked directly. Directed cases then separate the following behaviours from each other: staging versus commit, the fetched word versus a later core write, the fixed-address select versus the incrementing select, a held or changing strobe versus a fresh falling edge, and a flag set versus a clear arriving in the same cycle.

// File: rtl/bhp_pkg.sv
// Package for the byte-wide host port.
// Holds the register-select encoding, the captured host command record and
// the byte ordering helpers that the register file uses.
// Assumes an 8-bit host bus and a 16-bit memory word.
package bhp_pkg;

    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        SEL_CTRL     = 2'b00,
        SEL_DATA_INC = 2'b01,
        SEL_ADDR     = 2'b10,
        SEL_DATA_FIX = 2'b11
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e            sel;
        logic                half;
        logic                rd;
        logic [BYTE_W-1:0]   wbyte;
    } host_cmd_t;

    // Return the byte of a word that belongs to the given half, under the byte order.
    function automatic logic [BYTE_W-1:0] pick_byte(input logic [WORD_W-1:0] word,
                                                    input logic high_first,
                                                    input logic second);
        if (high_first ^ second)
            return word[WORD_W-1:BYTE_W];
        return word[BYTE_W-1:0];
    endfunction

    // Assemble a word from the staged first byte and the incoming second byte.
    function automatic logic [WORD_W-1:0] join_bytes(input logic [BYTE_W-1:0] first_b,
                                                     input logic [BYTE_W-1:0] second_b,
                                                     input logic high_first);
        if (high_first)
            return {first_b, second_b};
        return {second_b, first_b};
    endfunction

endpackage

// File: rtl/bhp_strobe_capture.sv
// Strobe capture for the byte-wide host port.
// Detects a falling edge of the host data strobe at the block clock. At that
// edge it latches the register select, the byte select, the direction and the
// write byte into a command record, and it raises a one-cycle valid.
// Assumes the strobe is synchronous to clk or has been synchronised upstream.
module bhp_strobe_capture
    import bhp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe_n,
    input  logic [1:0]        sel,
    input  logic              half,
    input  logic              rd,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              cmd_v,
    output host_cmd_t         cmd
);

    logic strobe_q;
    logic fall;

    // Falling edge: the strobe was high last cycle and is low now.
    assign fall = strobe_q & ~strobe_n;

    // Track the previous strobe level; a reset value of high means no idle edge is missed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe_q <= 1'b1;
        else
            strobe_q <= strobe_n;
    end

    // Raise valid for exactly the cycle after a falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_v <= 1'b0;
        else
            cmd_v <= fall;
    end

    // Latch the command fields only at the falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd <= '0;
        else if (fall)
            cmd <= '{sel: reg_sel_e'(sel), half: half, rd: rd, wbyte: wbyte};
    end

endmodule

// File: rtl/bhp_regs.sv
// Register file of the byte-wide host port.
// Holds the control bits (byte order and host flag), the address register, a
// staging byte for writes and a holding word for reads. It executes one
// captured host command per valid. It produces the memory write strobe, the
// assembled word and the host read byte.
// Assumes mem_q carries the word at addr_q as it stood at the previous edge.
module bhp_regs
    import bhp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_v,
    input  host_cmd_t         cmd,
    input  logic [WORD_W-1:0] mem_q,
    input  logic              core_flag_clr,
    output logic [ADDR_W-1:0] addr_q,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    output logic              host_flag
);

    localparam int PAD_W = WORD_W - ADDR_W;

    logic              order_hi;
    logic [BYTE_W-1:0] stage_q;
    logic [WORD_W-1:0] hold_q;
    logic              is_data;
    logic              do_write;
    logic              do_read;
    logic              flag_set;
    logic [WORD_W-1:0] joined;
    logic [WORD_W-1:0] addr_word;

    // Decode the command into its broad classes.
    always_comb begin
        is_data  = (cmd.sel == SEL_DATA_INC) || (cmd.sel == SEL_DATA_FIX);
        do_write = cmd_v && !cmd.rd;
        do_read  = cmd_v && cmd.rd;
        joined   = join_bytes(stage_q, cmd.wbyte, order_hi);
        addr_word = {{PAD_W{1'b0}}, addr_q};
        flag_set = do_write && (cmd.sel == SEL_CTRL) && !cmd.half && cmd.wbyte[1];
    end

    // A data write commits only with its second byte.
    assign mem_we    = do_write && is_data && cmd.half;
    assign mem_wdata = joined;

    // Control byte-order bit: first-byte control writes only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            order_hi <= 1'b0;
        else if (do_write && (cmd.sel == SEL_CTRL) && !cmd.half)
            order_hi <= cmd.wbyte[0];
    end

    // Host flag: a host set beats a core clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_flag <= 1'b0;
        else if (flag_set)
            host_flag <= 1'b1;
        else if (core_flag_clr)
            host_flag <= 1'b0;
    end

    // Staging byte for the first half of address and data writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (do_write && !cmd.half && (cmd.sel != SEL_CTRL))
            stage_q <= cmd.wbyte;
    end

    // Holding word: captured on a first-byte data read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_q <= '0;
        else if (do_read && is_data && !cmd.half)
            hold_q <= mem_q;
    end

    // Address register: byte-wise load, and post-increment after a second data byte.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (cmd_v) begin
            if (!cmd.rd && (cmd.sel == SEL_ADDR) && cmd.half)
                addr_q <= joined[ADDR_W-1:0];
            else if ((cmd.sel == SEL_DATA_INC) && cmd.half)
                addr_q <= addr_q + ADDR_W'(1);
        end
    end

    // Host read byte: updated only by read commands.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (do_read) begin
            unique case (cmd.sel)
                SEL_CTRL:     host_rdata <= cmd.half ? '0 : {6'b0, host_flag, order_hi};
                SEL_ADDR:     host_rdata <= pick_byte(addr_word, order_hi, cmd.half);
                SEL_DATA_INC,
                SEL_DATA_FIX: host_rdata <= cmd.half ? pick_byte(hold_q, order_hi, 1'b1)
                                                     : pick_byte(mem_q, order_hi, 1'b0);
                default:      host_rdata <= host_rdata;
            endcase
        end
    end

endmodule

// File: rtl/bhp_word_ram.sv
// Two-port word memory for the byte-wide host port.
// The host port reads its address every cycle into a registered output and
// writes on request. The core port reads and writes with one cycle of read
// latency. When both ports write the same word in one cycle, the core wins.
// Assumes the depth is 2**ADDR_W words.
module bhp_word_ram #(
    parameter int ADDR_W = 10,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] h_addr,
    input  logic              h_we,
    input  logic [WORD_W-1:0] h_wdata,
    output logic [WORD_W-1:0] h_q,
    input  logic              c_en,
    input  logic              c_we,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [WORD_W-1:0] c_wdata,
    output logic [WORD_W-1:0] c_q
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] mem [DEPTH];

    // Storage writes; the core write is placed last so that it takes priority.
    always_ff @(posedge clk) begin
        if (h_we)
            mem[h_addr] <= h_wdata;
        if (c_en && c_we)
            mem[c_addr] <= c_wdata;
    end

    // Host-side read: continuous fetch of the current host address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            h_q <= '0;
        else
            h_q <= mem[h_addr];
    end

    // Core-side read on an enabled non-write access.
    always_ff @(posedge clk) begin
        if (!rst_n)
            c_q <= '0;
        else if (c_en && !c_we)
            c_q <= mem[c_addr];
    end

endmodule

// File: rtl/byte_host_port.sv
// Byte-wide host port: top level.
// An 8-bit host reaches a 16-bit, 2**ADDR_W-word memory through control,
// address and data registers, using two byte transfers per word. A core-side
// port shares the memory and receives a host-to-core flag.
// Assumes host_strobe_n is synchronous to clk.
module byte_host_port
    import bhp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_strobe_n,
    input  logic [1:0]        host_sel,
    input  logic              host_half,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic              host_flag,
    input  logic              core_en,
    input  logic              core_we,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [15:0]       core_wdata,
    output logic [15:0]       core_rdata,
    input  logic              core_flag_clr
);

    logic              cmd_v;
    host_cmd_t         cmd;
    logic [ADDR_W-1:0] addr_q;
    logic              mem_we;
    logic [WORD_W-1:0] mem_wdata;
    logic [WORD_W-1:0] mem_q;

    bhp_strobe_capture u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_n (host_strobe_n),
        .sel      (host_sel),
        .half     (host_half),
        .rd       (host_rd),
        .wbyte    (host_wdata),
        .cmd_v    (cmd_v),
        .cmd      (cmd)
    );

    bhp_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_v         (cmd_v),
        .cmd           (cmd),
        .mem_q         (mem_q),
        .core_flag_clr (core_flag_clr),
        .addr_q        (addr_q),
        .mem_we        (mem_we),
        .mem_wdata     (mem_wdata),
        .host_rdata    (host_rdata),
        .host_flag     (host_flag)
    );

    bhp_word_ram #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .h_addr  (addr_q),
        .h_we    (mem_we),
        .h_wdata (mem_wdata),
        .h_q     (mem_q),
        .c_en    (core_en),
        .c_we    (core_we),
        .c_addr  (core_addr),
        .c_wdata (core_wdata),
        .c_q     (core_rdata)
    );

endmodule

// File: rtl/bhp_checker.sv
// Assertion checker for the byte-wide host port, bound into the top module.
// Watches the captured command, the address register and the host flag.
module bhp_checker
    import bhp_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_v,
    input host_cmd_t         cmd,
    input logic [ADDR_W-1:0] addr_q,
    input logic              host_flag,
    input logic              core_flag_clr
);

    // R2: a falling edge yields one command, never two in a row.
    p_single_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_v |=> !cmd_v);

    // R6: the incrementing second byte at the top address wraps to zero.
    p_addr_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v && cmd.sel == SEL_DATA_INC && cmd.half && addr_q == '1) |=> (addr_q == '0));

    // R6: the address moves only when a command executes.
    p_addr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_v |=> $stable(addr_q));

    // R6: the fixed-address data select never moves the address.
    p_fixed_no_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_v && cmd.sel == SEL_DATA_FIX) |=> $stable(addr_q));

    // R8: the flag stays set until the core clears it.
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_flag && !core_flag_clr) |=> host_flag);

    // R8: a clear with no simultaneous host set drops the flag.
    p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (core_flag_clr && !(cmd_v && !cmd.rd && cmd.sel == SEL_CTRL && !cmd.half && cmd.wbyte[1]))
        |=> !host_flag);

endmodule

bind byte_host_port bhp_checker #(.ADDR_W(ADDR_W)) u_bhp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_v         (cmd_v),
    .cmd           (cmd),
    .addr_q        (addr_q),
    .host_flag     (host_flag),
    .core_flag_clr (core_flag_clr)
);

// File: tb/test_byte_host_port.sv
module test_byte_host_port;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 10;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_strobe_n = 1'b1;
    logic [1:0]    host_sel = 2'b00;
    logic          host_half = 1'b0;
    logic          host_rd = 1'b0;
    logic [7:0]    host_wdata = 8'h00;
    logic [7:0]    host_rdata;
    logic          host_flag;
    logic          core_en = 1'b0;
    logic          core_we = 1'b0;
    logic [AW-1:0] core_addr = '0;
    logic [15:0]   core_wdata = 16'h0;
    logic [15:0]   core_rdata;
    logic          core_flag_clr = 1'b0;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_host_port #(.ADDR_W(AW)) i_byte_host_port (
        .clk           (clk),
        .rst_n         (rst_n),
        .host_strobe_n (host_strobe_n),
        .host_sel      (host_sel),
        .host_half     (host_half),
        .host_rd       (host_rd),
        .host_wdata    (host_wdata),
        .host_rdata    (host_rdata),
        .host_flag     (host_flag),
        .core_en       (core_en),
        .core_we       (core_we),
        .core_addr     (core_addr),
        .core_wdata    (core_wdata),
        .core_rdata    (core_rdata),
        .core_flag_clr (core_flag_clr)
    );

    function automatic logic [15:0] pattern(input int i);
        return 16'(i * 40503) ^ 16'h5A3C;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One host byte transfer; rb is the read byte sampled after the update.
    task automatic host_op(input logic [1:0] sel, input logic half, input logic rd,
                           input logic [7:0] wb, output logic [7:0] rb);
        @(negedge clk);
        host_sel = sel; host_half = half; host_rd = rd; host_wdata = wb;
        host_strobe_n = 1'b0;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        rb = host_rdata;
        host_strobe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_word(input logic [1:0] sel, input logic [15:0] w, input logic hi_first);
        logic [7:0] dummy;
        host_op(sel, 1'b0, 1'b0, hi_first ? w[15:8] : w[7:0], dummy);
        host_op(sel, 1'b1, 1'b0, hi_first ? w[7:0] : w[15:8], dummy);
    endtask

    task automatic rd_word(input logic [1:0] sel, input logic hi_first, output logic [15:0] w);
        logic [7:0] b0, b1;
        host_op(sel, 1'b0, 1'b1, 8'h00, b0);
        host_op(sel, 1'b1, 1'b1, 8'h00, b1);
        w = hi_first ? {b0, b1} : {b1, b0};
    endtask

    task automatic set_ctrl(input logic [7:0] v);
        logic [7:0] dummy;
        host_op(2'b00, 1'b0, 1'b0, v, dummy);
    endtask

    task automatic core_write(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        core_en = 1'b1; core_we = 1'b1; core_addr = a; core_wdata = d;
        @(negedge clk);
        core_en = 1'b0; core_we = 1'b0;
    endtask

    task automatic core_read(input logic [AW-1:0] a, output logic [15:0] d);
        @(negedge clk);
        core_en = 1'b1; core_we = 1'b0; core_addr = a;
        @(negedge clk);
        core_en = 1'b0;
        d = core_rdata;
    endtask

    // Watchdog: an expired run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 150000);
        bad++;
        total++;
        $display("FAIL watchdog all-requirements actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] w;
        logic [7:0]  b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        check("R10 rdata", 32'(host_rdata), 32'h0);
        check("R10 flag", 32'(host_flag), 32'h0);
        host_op(2'b00, 1'b0, 1'b1, 8'h00, b);
        check("R10 control", 32'(b), 32'h0);
        rd_word(2'b10, 1'b0, w);
        check("R10 address", 32'(w), 32'h0);

        // R7: address load and readback, truncation to 10 bits
        wr_word(2'b10, 16'h02A5, 1'b0);
        rd_word(2'b10, 1'b0, w);
        check("R7 addr readback", 32'(w), 32'h02A5);
        wr_word(2'b10, 16'hFFFF, 1'b0);
        rd_word(2'b10, 1'b0, w);
        check("R7 addr truncated", 32'(w), 32'h03FF);

        // R1 R3 R9: fill every word with the incrementing data select, low first
        wr_word(2'b10, 16'h0000, 1'b0);
        for (int i = 0; i < DEPTH; i++)
            wr_word(2'b01, pattern(i), 1'b0);
        rd_word(2'b10, 1'b0, w);
        check("R6 wrap after sweep", 32'(w), 32'h0);
        for (int i = 0; i < DEPTH; i++) begin
            core_read(AW'(i), w);
            check("R1 R3 R9 core sweep", 32'(w), 32'(pattern(i)));
        end

        // R5: high-first order, host read sweep
        set_ctrl(8'h01);
        host_op(2'b00, 1'b0, 1'b1, 8'h00, b);
        check("R8 control read order", 32'(b), 32'h01);
        host_op(2'b00, 1'b1, 1'b1, 8'h00, b);
        check("R8 control second byte", 32'(b), 32'h00);
        wr_word(2'b10, 16'h0000, 1'b1);
        for (int i = 0; i < DEPTH; i++) begin
            rd_word(2'b01, 1'b1, w);
            check("R5 R1 host sweep high-first", 32'(w), 32'(pattern(i)));
        end
        wr_word(2'b10, 16'h0005, 1'b1);
        w = pattern(5);
        host_op(2'b11, 1'b0, 1'b1, 8'h00, b);
        check("R5 first byte high", 32'(b), 32'(w[15:8]));
        host_op(2'b11, 1'b1, 1'b1, 8'h00, b);
        set_ctrl(8'h00);
        host_op(2'b11, 1'b0, 1'b1, 8'h00, b);
        check("R5 first byte low", 32'(b), 32'(w[7:0]));
        host_op(2'b11, 1'b1, 1'b1, 8'h00, b);
        check("R5 second byte high", 32'(b), 32'(w[15:8]));

        // R6: fixed select does not step, first byte does not step
        wr_word(2'b10, 16'h0007, 1'b0);
        rd_word(2'b11, 1'b0, w);
        rd_word(2'b11, 1'b0, w);
        check("R6 fixed read data", 32'(w), 32'(pattern(7)));
        rd_word(2'b10, 1'b0, w);
        check("R6 fixed no step", 32'(w), 32'h7);
        host_op(2'b01, 1'b0, 1'b1, 8'h00, b);
        rd_word(2'b10, 1'b0, w);
        check("R6 first byte no step", 32'(w), 32'h7);
        host_op(2'b01, 1'b0, 1'b1, 8'h00, b);
        host_op(2'b01, 1'b1, 1'b1, 8'h00, b);
        rd_word(2'b10, 1'b0, w);
        check("R6 second byte steps", 32'(w), 32'h8);

        // R3: staging only until the second byte
        wr_word(2'b10, 16'h0009, 1'b0);
        host_op(2'b11, 1'b0, 1'b0, 8'hEE, b);
        core_read(AW'(9), w);
        check("R3 first byte no commit", 32'(w), 32'(pattern(9)));
        host_op(2'b11, 1'b1, 1'b0, 8'hDD, b);
        core_read(AW'(9), w);
        check("R3 commit on second byte", 32'(w), 32'hDDEE);

        // R4: second byte comes from the word fetched on the first byte
        wr_word(2'b10, 16'd20, 1'b0);
        host_op(2'b11, 1'b0, 1'b1, 8'h00, b);
        check("R4 first byte", 32'(b), 32'(pattern(20) & 16'h00FF));
        core_write(AW'(20), 16'h1234);
        host_op(2'b11, 1'b1, 1'b1, 8'h00, b);
        check("R4 held second byte", 32'(b), 32'(pattern(20) >> 8));
        rd_word(2'b11, 1'b0, w);
        check("R4 fresh fetch", 32'(w), 32'h1234);

        // R9: core write seen by the host
        core_write(AW'(30), 16'hBEEF);
        wr_word(2'b10, 16'd30, 1'b0);
        rd_word(2'b11, 1'b0, w);
        check("R9 core write to host", 32'(w), 32'hBEEF);

        // R11: latency and hold of the read byte
        wr_word(2'b10, 16'd31, 1'b0);
        @(negedge clk);
        host_sel = 2'b11; host_half = 1'b0; host_rd = 1'b1; host_strobe_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R11 not yet updated", 32'(host_rdata), 32'h00BE);
        @(posedge clk);
        @(negedge clk);
        check("R11 updated", 32'(host_rdata), 32'(pattern(31) & 16'h00FF));
        host_strobe_n = 1'b1;
        @(negedge clk);
        host_op(2'b11, 1'b1, 1'b1, 8'h00, b);
        host_op(2'b10, 1'b0, 1'b0, 8'h55, b);
        check("R11 hold over write", 32'(b), 32'(pattern(31) >> 8));

        // R8: flag set, no effect of zero, clear, set beats clear
        check("R8 flag idle", 32'(host_flag), 32'h0);
        set_ctrl(8'h02);
        check("R8 flag set", 32'(host_flag), 32'h1);
        host_op(2'b00, 1'b0, 1'b1, 8'h00, b);
        check("R8 control read flag", 32'(b), 32'h02);
        set_ctrl(8'h00);
        check("R8 zero write no effect", 32'(host_flag), 32'h1);
        @(negedge clk);
        core_flag_clr = 1'b1;
        @(negedge clk);
        core_flag_clr = 1'b0;
        check("R8 core clear", 32'(host_flag), 32'h0);
        fork
            set_ctrl(8'h02);
            begin
                @(negedge clk);
                @(negedge clk);
                core_flag_clr = 1'b1;
                @(negedge clk);
                core_flag_clr = 1'b0;
            end
        join
        check("R8 set wins over clear", 32'(host_flag), 32'h1);
        @(negedge clk);
        core_flag_clr = 1'b1;
        @(negedge clk);
        core_flag_clr = 1'b0;

        // R2: fields changed while the strobe is low are ignored
        @(negedge clk);
        host_sel = 2'b00; host_half = 1'b0; host_rd = 1'b0; host_wdata = 8'h00;
        host_strobe_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        host_wdata = 8'h03;
        repeat (4) @(negedge clk);
        host_strobe_n = 1'b1;
        @(negedge clk);
        check("R2 late field change flag", 32'(host_flag), 32'h0);
        host_op(2'b00, 1'b0, 1'b1, 8'h00, b);
        check("R2 late field change control", 32'(b), 32'h00);

        // R2: a strobe held low performs one transfer only
        wr_word(2'b10, 16'd100, 1'b0);
        host_op(2'b01, 1'b0, 1'b0, 8'h11, b);
        @(negedge clk);
        host_sel = 2'b01; host_half = 1'b1; host_rd = 1'b0; host_wdata = 8'h22;
        host_strobe_n = 1'b0;
        repeat (6) @(negedge clk);
        host_strobe_n = 1'b1;
        @(negedge clk);
        rd_word(2'b10, 1'b0, w);
        check("R2 held strobe single step", 32'(w), 32'd101);
        core_read(AW'(100), w);
        check("R2 held strobe data", 32'(w), 32'h2211);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule